// File: doc/BRIEF.md
# Partition Freeze State Table with Transaction Filter

This block keeps an isolation state for every partition number served by one host bridge. Each partition owns two freeze flags: one guards memory-mapped register traffic and the other guards device-initiated memory traffic and message interrupts. When an error is reported against a partition, both flags are raised in the same clock edge. Software then lowers each flag separately through a small register port, and can read both flags for any partition at any time.

Every transaction passes through a one-entry register stage. The stage looks up the partition of each request. If the relevant flag is clear, the request goes downstream unchanged. If the flag is set, the block answers the request locally. A write is dropped and acknowledged. A read is answered with all-ones data. A message interrupt is discarded with a blocked status. The requester therefore always receives a completion, and a frozen device cannot reach memory or the interrupt controller.

Top module: `pfz_unit`

## Requirements
- R1: After reset every freeze flag of every partition reads 0, `out_valid` and `rsp_valid` are 0, and `req_ready` is 1.
- R2: A freeze event (`frz_evt_valid` high for one cycle) sets both flags of partition `frz_evt_part`. The software read port shows both flags as 1 from the next cycle on.
- R3: A software clear lowers only the flags selected by `sw_clr_mmio` and `sw_clr_dma` for `sw_clr_part`. The other flag of that partition and all other partitions keep their values.
- R4: If a freeze event and a software clear target the same partition in the same cycle, the freeze wins and both flags read 1 afterwards.
- R5: A write (`req_write`=1) of class memory-mapped (`req_cls`=0) or device memory (`req_cls`=1) whose relevant flag is set is not forwarded. The cycle after acceptance, the block returns `rsp_code`=1 (acknowledge) with `rsp_data`=0.
- R6: A read (`req_write`=0) of class 0 or 1 whose relevant flag is set is not forwarded. The cycle after acceptance, the block returns `rsp_code`=2 with `rsp_data` all ones.
- R7: A message interrupt (`req_cls`=2; the reserved value 3 is handled the same way) whose partition has the device-memory flag set is not forwarded. The block returns `rsp_code`=3 (blocked) with `rsp_data`=0, whatever the value of `req_write`.
- R8: Class 0 requests are judged on the memory-mapped flag alone. Classes 1, 2 and 3 are judged on the device-memory flag alone.
- R9: A request whose relevant flag is clear appears on the `out_*` port with unchanged class, direction, partition, address and data. While `out_ready` is low, the held payload stays stable and `req_ready` is 0.
- R10: A freeze event for the partition of a request accepted in the same cycle already counts as frozen for that request. A clear in the same cycle does not unfreeze it.
- R11: An accepted request produces exactly one result, either `out_valid` or `rsp_valid`, in the cycle after acceptance. `rsp_part` names the partition of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frz_evt_valid | input | 1 | Error event: freeze a partition |
| frz_evt_part | input | 8 | Partition to freeze |
| sw_clr_valid | input | 1 | Software clear strobe |
| sw_clr_part | input | 8 | Partition to clear |
| sw_clr_mmio | input | 1 | Clear the memory-mapped flag |
| sw_clr_dma | input | 1 | Clear the device-memory flag |
| sw_rd_part | input | 8 | Partition selected on the read port |
| sw_rd_mmio | output | 1 | Memory-mapped flag of `sw_rd_part` |
| sw_rd_dma | output | 1 | Device-memory flag of `sw_rd_part` |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| req_cls | input | 2 | 0 memory-mapped, 1 device memory, 2 message interrupt, 3 reserved (as 2) |
| req_write | input | 1 | 1 write, 0 read |
| req_part | input | 8 | Partition number of the request |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Write data |
| out_valid | output | 1 | Forwarded request valid |
| out_ready | input | 1 | Downstream accepts the forwarded request |
| out_cls | output | 2 | Forwarded class |
| out_write | output | 1 | Forwarded direction |
| out_part | output | 8 | Forwarded partition |
| out_addr | output | 32 | Forwarded address |
| out_wdata | output | 32 | Forwarded write data |
| rsp_valid | output | 1 | Local completion valid (one cycle) |
| rsp_code | output | 2 | 1 acknowledge, 2 all-ones read, 3 blocked interrupt |
| rsp_part | output | 8 | Partition of the locally completed request |
| rsp_data | output | 32 | Completion data |

## Verification
Three things can fall on the same clock edge: a freeze event, a software clear and an accepted request, all on one partition. The random phase draws partition numbers from a pool of nine values, so freeze and clear often hit the same entry. The directed cases force both collisions on purpose. The bench judges each case by reading both flags back on the software port after the edge and by checking the class of completion given to the colliding request. Its reference model applies the clear first and then the freeze, and it lets a same-cycle freeze affect the request decision.

// File: rtl/pfz_pkg.sv
package pfz_pkg;

    // Transaction classes as seen on the request port.
    localparam logic [1:0] CLS_MMIO = 2'd0;
    localparam logic [1:0] CLS_DMA  = 2'd1;
    localparam logic [1:0] CLS_MSI  = 2'd2;
    localparam logic [1:0] CLS_RSVD = 2'd3;

    // Local completion codes.
    localparam logic [1:0] RSP_NONE  = 2'd0;
    localparam logic [1:0] RSP_ACK   = 2'd1;
    localparam logic [1:0] RSP_ONES  = 2'd2;
    localparam logic [1:0] RSP_BLOCK = 2'd3;

endpackage

// File: rtl/pfz_table.sv
// Per-partition freeze flags: set together by an error event, cleared
// individually by software. Clear is applied first, then freeze, so a
// same-cycle freeze always wins.
module pfz_table #(
    parameter int PARTS  = 256,
    parameter int PART_W = $clog2(PARTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frz_v,
    input  logic [PART_W-1:0] frz_part,
    input  logic              clr_v,
    input  logic [PART_W-1:0] clr_part,
    input  logic              clr_mmio,
    input  logic              clr_dma,
    input  logic [PART_W-1:0] rd_part,
    output logic              rd_mmio,
    output logic              rd_dma,
    input  logic [PART_W-1:0] lk_part,
    output logic              lk_mmio,
    output logic              lk_dma
);

    typedef struct packed {
        logic [PARTS-1:0] mmio;
        logic [PARTS-1:0] dma;
    } tbl_t;

    tbl_t             st_d, st_q;
    logic [PARTS-1:0] frz_hot;
    logic [PARTS-1:0] clr_hot;

    // one-hot decode of both write ports
    always_comb begin
        frz_hot = '0;
        clr_hot = '0;
        if (frz_v) frz_hot[frz_part] = 1'b1;
        if (clr_v) clr_hot[clr_part] = 1'b1;
    end

    always_comb begin
        st_d      = st_q;
        st_d.mmio = (st_q.mmio & ~(clr_hot & {PARTS{clr_mmio}})) | frz_hot;
        st_d.dma  = (st_q.dma  & ~(clr_hot & {PARTS{clr_dma}}))  | frz_hot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_mmio = st_q.mmio[rd_part];
    assign rd_dma  = st_q.dma[rd_part];
    assign lk_mmio = st_q.mmio[lk_part];
    assign lk_dma  = st_q.dma[lk_part];

    // R2: an event raises both flags of its entry
    p_freeze_sets_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frz_v |=> (st_q.mmio[$past(frz_part)] && st_q.dma[$past(frz_part)]));

    // R4: freeze beats a same-entry clear
    p_freeze_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_v && clr_v && frz_part == clr_part)
        |=> (st_q.mmio[$past(clr_part)] && st_q.dma[$past(clr_part)]));

    // R3: a selected clear lowers the flag when no freeze competes
    p_clear_mmio_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_v && clr_mmio && !frz_v) |=> !st_q.mmio[$past(clr_part)]);

    // R3: an unselected flag keeps its value
    p_clear_keeps_dma_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_v && !clr_dma && !frz_v)
        |=> (st_q.dma[$past(clr_part)] == $past(st_q.dma[clr_part])));

endmodule

// File: rtl/pfz_classify.sv
// Decides how a request is handled from the flags of its partition,
// including a freeze event arriving in the same cycle.
module pfz_classify
    import pfz_pkg::*;
#(
    parameter int PART_W = 8
) (
    input  logic [1:0]        cls,
    input  logic              write,
    input  logic [PART_W-1:0] part,
    input  logic              lk_mmio,
    input  logic              lk_dma,
    input  logic              frz_v,
    input  logic [PART_W-1:0] frz_part,
    output logic [1:0]        code
);

    logic flag;
    logic frozen;

    always_comb begin
        // R8: register traffic uses its own flag, everything else the DMA flag
        flag   = (cls == CLS_MMIO) ? lk_mmio : lk_dma;
        // R10: same-cycle freeze already applies
        frozen = flag | (frz_v && (frz_part == part));
        if (!frozen)      code = RSP_NONE;
        else if (cls[1])  code = RSP_BLOCK;
        else if (write)   code = RSP_ACK;
        else              code = RSP_ONES;
    end

endmodule

// File: rtl/pfz_stage.sv
// One-entry register stage: forwards clean requests downstream with a
// valid/ready handshake, or completes filtered ones locally in one cycle.
module pfz_stage
    import pfz_pkg::*;
#(
    parameter int PART_W = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_cls,
    input  logic              req_write,
    input  logic [PART_W-1:0] req_part,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        acc_code,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [1:0]        out_cls,
    output logic              out_write,
    output logic [PART_W-1:0] out_part,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_wdata,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [PART_W-1:0] rsp_part,
    output logic [DATA_W-1:0] rsp_data
);

    typedef struct packed {
        logic              valid;
        logic              local_rsp;
        logic [1:0]        code;
        logic [1:0]        cls;
        logic              write;
        logic [PART_W-1:0] part;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } stg_t;

    stg_t stg_d, stg_q;

    // local completions drain unconditionally; forwarded ones wait
    assign req_ready = !stg_q.valid || stg_q.local_rsp || out_ready;

    always_comb begin
        stg_d = stg_q;
        if (req_ready) begin
            stg_d.valid     = req_valid;
            stg_d.local_rsp = (acc_code != RSP_NONE);
            stg_d.code      = acc_code;
            stg_d.cls       = req_cls;
            stg_d.write     = req_write;
            stg_d.part      = req_part;
            stg_d.addr      = req_addr;
            stg_d.wdata     = req_wdata;
            stg_d.rdata     = (acc_code == RSP_ONES) ? {DATA_W{1'b1}} : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign out_valid = stg_q.valid && !stg_q.local_rsp;
    assign out_cls   = stg_q.cls;
    assign out_write = stg_q.write;
    assign out_part  = stg_q.part;
    assign out_addr  = stg_q.addr;
    assign out_wdata = stg_q.wdata;

    assign rsp_valid = stg_q.valid && stg_q.local_rsp;
    assign rsp_code  = stg_q.code;
    assign rsp_part  = stg_q.part;
    assign rsp_data  = stg_q.rdata;

    // R11: every accepted request yields a result in the next cycle
    p_one_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (out_valid != rsp_valid));

    // R9: a stalled forward holds its payload
    p_hold_payload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready)
        |=> (out_valid && $stable(out_addr) && $stable(out_wdata) && $stable(out_part)));

    // R5: a filtered request never reaches the downstream port
    p_no_forward_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && acc_code != RSP_NONE) |=> (rsp_valid && !out_valid));

    // R6: a filtered read returns all ones
    p_ones_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && acc_code != RSP_NONE && !req_write && !req_cls[1])
        |=> (rsp_code == RSP_ONES && rsp_data == {DATA_W{1'b1}}));

endmodule

// File: rtl/pfz_unit.sv
// Partition freeze table plus transaction filter for one host bridge.
module pfz_unit #(
    parameter int PARTS  = 256,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int PART_W = $clog2(PARTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frz_evt_valid,
    input  logic [PART_W-1:0] frz_evt_part,
    input  logic              sw_clr_valid,
    input  logic [PART_W-1:0] sw_clr_part,
    input  logic              sw_clr_mmio,
    input  logic              sw_clr_dma,
    input  logic [PART_W-1:0] sw_rd_part,
    output logic              sw_rd_mmio,
    output logic              sw_rd_dma,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_cls,
    input  logic              req_write,
    input  logic [PART_W-1:0] req_part,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [1:0]        out_cls,
    output logic              out_write,
    output logic [PART_W-1:0] out_part,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_wdata,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [PART_W-1:0] rsp_part,
    output logic [DATA_W-1:0] rsp_data
);

    logic       lk_mmio;
    logic       lk_dma;
    logic [1:0] acc_code;

    pfz_table #(.PARTS(PARTS), .PART_W(PART_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .frz_v    (frz_evt_valid),
        .frz_part (frz_evt_part),
        .clr_v    (sw_clr_valid),
        .clr_part (sw_clr_part),
        .clr_mmio (sw_clr_mmio),
        .clr_dma  (sw_clr_dma),
        .rd_part  (sw_rd_part),
        .rd_mmio  (sw_rd_mmio),
        .rd_dma   (sw_rd_dma),
        .lk_part  (req_part),
        .lk_mmio  (lk_mmio),
        .lk_dma   (lk_dma)
    );

    pfz_classify #(.PART_W(PART_W)) u_classify (
        .cls      (req_cls),
        .write    (req_write),
        .part     (req_part),
        .lk_mmio  (lk_mmio),
        .lk_dma   (lk_dma),
        .frz_v    (frz_evt_valid),
        .frz_part (frz_evt_part),
        .code     (acc_code)
    );

    pfz_stage #(.PART_W(PART_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_cls   (req_cls),
        .req_write (req_write),
        .req_part  (req_part),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .acc_code  (acc_code),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_cls   (out_cls),
        .out_write (out_write),
        .out_part  (out_part),
        .out_addr  (out_addr),
        .out_wdata (out_wdata),
        .rsp_valid (rsp_valid),
        .rsp_code  (rsp_code),
        .rsp_part  (rsp_part),
        .rsp_data  (rsp_data)
    );

    // R1: nothing leaves the block in the cycle after reset release
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && !rsp_valid));

endmodule

// File: tb/tb_pfz_unit.sv
`timescale 1ns/1ps
module tb_pfz_unit;

    localparam int PARTS  = 256;
    localparam int PW     = 8;
    localparam int AW     = 32;
    localparam int DW     = 32;
    localparam int WDOG   = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frz_evt_valid = 1'b0;
    logic [PW-1:0] frz_evt_part = '0;
    logic          sw_clr_valid = 1'b0;
    logic [PW-1:0] sw_clr_part = '0;
    logic          sw_clr_mmio = 1'b0;
    logic          sw_clr_dma = 1'b0;
    logic [PW-1:0] sw_rd_part = '0;
    logic          sw_rd_mmio, sw_rd_dma;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_cls = '0;
    logic          req_write = 1'b0;
    logic [PW-1:0] req_part = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [1:0]    out_cls;
    logic          out_write;
    logic [PW-1:0] out_part;
    logic [AW-1:0] out_addr;
    logic [DW-1:0] out_wdata;
    logic          rsp_valid;
    logic [1:0]    rsp_code;
    logic [PW-1:0] rsp_part;
    logic [DW-1:0] rsp_data;

    pfz_unit dut (.*);

    always #2 clk = ~clk;   // 250 MHz

    int  n_chk = 0;
    int  n_err = 0;
    int  cyc   = 0;
    bit  mm_m [PARTS];
    bit  dm_m [PARTS];

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG) begin
            n_err++;
            $display("FAIL R11 watchdog actual=%0d expected<=%0d", cyc, WDOG);
            report();
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected completion code from the requirement text (R5..R8, R10)
    function automatic logic [1:0] exp_code(input logic [1:0] c, input logic w,
                                            input logic [PW-1:0] p, input logic fv,
                                            input logic [PW-1:0] fp);
        logic f;
        f = ((c == 2'd0) ? mm_m[p] : dm_m[p]) | (fv && fp == p);
        if (!f)        return 2'd0;
        else if (c[1]) return 2'd3;
        else if (w)    return 2'd1;
        else           return 2'd2;
    endfunction

    // One cycle with the currently driven inputs; assumes out_ready=1.
    task automatic tick(input string ctx);
        logic          acc;
        logic [1:0]    ec, c;
        logic          w;
        logic [PW-1:0] p;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic          fv, cv, cm, cd;
        logic [PW-1:0] fp, cp;
        string         rt;
        acc = req_valid && req_ready;
        c = req_cls; w = req_write; p = req_part; a = req_addr; d = req_wdata;
        fv = frz_evt_valid; fp = frz_evt_part;
        cv = sw_clr_valid; cp = sw_clr_part; cm = sw_clr_mmio; cd = sw_clr_dma;
        ec = exp_code(c, w, p, fv, fp);
        @(posedge clk); #1;
        // model: clear first, then freeze (R4)
        if (cv) begin
            if (cm) mm_m[cp] = 1'b0;
            if (cd) dm_m[cp] = 1'b0;
        end
        if (fv) begin
            mm_m[fp] = 1'b1;
            dm_m[fp] = 1'b1;
        end
        rt = (ec == 2'd1) ? "R5" : (ec == 2'd2) ? "R6" : (ec == 2'd3) ? "R7" : "R9";
        if (acc) begin
            chk({"R11 one result ", ctx}, {out_valid, rsp_valid}, (ec == 2'd0) ? 2'b10 : 2'b01);
            if (ec == 2'd0) begin
                chk({rt, " fwd cls ", ctx},   out_cls,   c);
                chk({rt, " fwd write ", ctx}, out_write, w);
                chk({rt, " fwd part ", ctx},  out_part,  p);
                chk({rt, " fwd addr ", ctx},  out_addr,  a);
                chk({rt, " fwd data ", ctx},  out_wdata, d);
            end else begin
                chk({rt, " rsp code ", ctx}, rsp_code, ec);
                chk({rt, " rsp data ", ctx}, rsp_data, (ec == 2'd2) ? {DW{1'b1}} : '0);
                chk({"R11 rsp part ", ctx}, rsp_part, p);
            end
        end else begin
            chk({"R11 idle ", ctx}, {out_valid, rsp_valid}, 2'b00);
        end
        chk({"R3 read flags ", ctx}, {sw_rd_mmio, sw_rd_dma},
            {mm_m[sw_rd_part], dm_m[sw_rd_part]});
    endtask

    task automatic idle_inputs();
        req_valid = 1'b0; frz_evt_valid = 1'b0; sw_clr_valid = 1'b0;
        sw_clr_mmio = 1'b0; sw_clr_dma = 1'b0;
    endtask

    task automatic set_req(input logic [1:0] c, input logic w, input logic [PW-1:0] p);
        req_valid = 1'b1; req_cls = c; req_write = w; req_part = p;
        req_addr = $urandom; req_wdata = $urandom;
    endtask

    function automatic logic [PW-1:0] pick_part();
        int r;
        r = $urandom_range(0, 8);
        return (r == 8) ? 8'd255 : PW'(r);
    endfunction

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < PARTS; i++) begin mm_m[i] = 1'b0; dm_m[i] = 1'b0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 out_valid", out_valid, 1'b0);
        chk("R1 rsp_valid", rsp_valid, 1'b0);
        chk("R1 req_ready", req_ready, 1'b1);
        for (int i = 0; i < 4; i++) begin
            sw_rd_part = (i == 3) ? 8'd255 : PW'(i * 70); #1;
            chk("R1 flags zero", {sw_rd_mmio, sw_rd_dma}, 2'b00);
        end

        // R2: freeze event on 5 sets both
        frz_evt_valid = 1'b1; frz_evt_part = 8'd5; sw_rd_part = 8'd5;
        tick("R2 freeze 5");
        idle_inputs();
        chk("R2 both set", {sw_rd_mmio, sw_rd_dma}, 2'b11);

        // R3: clear only the MMIO flag of 5
        sw_clr_valid = 1'b1; sw_clr_part = 8'd5; sw_clr_mmio = 1'b1;
        tick("R3 clear mmio");
        idle_inputs();
        chk("R3 mmio cleared dma kept", {sw_rd_mmio, sw_rd_dma}, 2'b01);

        // R8: MMIO read forwarded, DMA read answered with ones, on the same partition
        set_req(2'd0, 1'b0, 8'd5); tick("R8 mmio read unfrozen flag");
        chk("R8 mmio forwarded", out_valid, 1'b1);
        set_req(2'd1, 1'b0, 8'd5); tick("R8 dma read frozen flag");
        chk("R8 dma read ones R6", rsp_data, {DW{1'b1}});
        idle_inputs();

        // R4: freeze and clear on 9 in the same cycle
        frz_evt_valid = 1'b1; frz_evt_part = 8'd9;
        sw_clr_valid = 1'b1; sw_clr_part = 8'd9; sw_clr_mmio = 1'b1; sw_clr_dma = 1'b1;
        sw_rd_part = 8'd9;
        tick("R4 collide");
        idle_inputs();
        chk("R4 freeze wins", {sw_rd_mmio, sw_rd_dma}, 2'b11);

        // R10: freeze on 20 with a write to 20 in the same cycle
        frz_evt_valid = 1'b1; frz_evt_part = 8'd20;
        set_req(2'd0, 1'b1, 8'd20);
        tick("R10 same-cycle freeze");
        chk("R10 write dropped R5", rsp_code, 2'd1);
        idle_inputs();

        // R10: clear of 20 in the same cycle as a read does not unfreeze it
        sw_clr_valid = 1'b1; sw_clr_part = 8'd20; sw_clr_mmio = 1'b1;
        set_req(2'd0, 1'b0, 8'd20);
        tick("R10 same-cycle clear");
        chk("R10 read still ones", rsp_code, 2'd2);
        idle_inputs();

        // R7: reserved class acts as interrupt, blocked on frozen 9
        set_req(2'd3, 1'b0, 8'd9); tick("R7 rsvd class");
        chk("R7 blocked", rsp_code, 2'd3);
        set_req(2'd2, 1'b1, 8'd9); tick("R7 msi");
        idle_inputs();

        // R9: back-pressure holds the forwarded request
        out_ready = 1'b0;
        set_req(2'd1, 1'b1, 8'd100);
        req_addr = 32'hCAFE_0100; req_wdata = 32'h1234_5678;
        @(posedge clk); #1;
        idle_inputs();
        chk("R11 forwarded next cycle", out_valid, 1'b1);
        chk("R9 ready low when stalled", req_ready, 1'b0);
        @(posedge clk); #1;
        chk("R9 held valid", out_valid, 1'b1);
        chk("R9 held addr", out_addr, 32'hCAFE_0100);
        chk("R9 held data", out_wdata, 32'h1234_5678);
        out_ready = 1'b1; #1;
        chk("R9 ready on drain", req_ready, 1'b1);
        @(posedge clk); #1;
        chk("R9 drained", out_valid, 1'b0);

        // random phase
        for (int k = 0; k < 4000; k++) begin
            idle_inputs();
            if ($urandom_range(0, 3) != 0)
                set_req(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), pick_part());
            if ($urandom_range(0, 7) == 0) begin
                frz_evt_valid = 1'b1; frz_evt_part = pick_part();
            end
            if ($urandom_range(0, 3) == 0) begin
                sw_clr_valid = 1'b1; sw_clr_part = pick_part();
                sw_clr_mmio = 1'($urandom_range(0, 1));
                sw_clr_dma  = 1'($urandom_range(0, 1));
            end
            sw_rd_part = pick_part();
            tick("random");
        end
        idle_inputs();
        report();
    end

endmodule